// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-mapped watchdog that supervises software with a windowed service rule. After reset it is dormant. Writing one exact 32-bit enable word to its control register loads a down-counter with a start value, which is the 12-bit preload field shifted left by a fixed amount. From then on the counter falls by one every clock. Software keeps the system alive by writing two key words in turn to the key register. The second word reloads the counter, but only while the service window is open. The window covers the final part of the period, so a service that arrives too soon counts as a fault, just like letting the counter run out.

The block handles a fault in one of two ways, chosen by a reaction register. It either asserts an interrupt-style output or asserts a reset-request output. The fault stays latched until software writes 1 to the fault bit of the status register. That write also reloads the counter and resumes supervision. Once enabled, the watchdog can only be stopped by reset. The live counter can be read back at any time.

The control sequence is held in a four-state machine:
- `ST_OFF`: dormant.
- `ST_RUN`: counting and waiting for the first key.
- `ST_ARMED`: first key seen, second key expected.
- `ST_TRIP`: fault latched, counter frozen.

Transitions:
- enable: `ST_OFF`→`ST_RUN`.
- first key: `ST_RUN`→`ST_ARMED`.
- good service: `ST_ARMED`→`ST_RUN`, with reload.
- broken sequence: `ST_ARMED`→`ST_RUN`, without reload.
- early service: `ST_ARMED`→`ST_TRIP`.
- expiry: `ST_RUN`/`ST_ARMED`→`ST_TRIP`.
- fault clear: `ST_TRIP`→`ST_RUN`, with reload.

Top module: `wdog_window`

## Requirements
- R1: After reset the block is dormant. Status reads 0, the counter reads 0, and both fault outputs are low. The reaction register reads 0x5 and the window register reads 0x05.
- R2: Only a write of exactly 0xA98559DA to the control register (0x90) starts the watchdog; any other value leaves it dormant. On enable, the counter (0xA0) loads preload<<SHIFT, using the preload from register 0x94 (bits 11:0). It then decreases by one per clock.
- R3: Once started, the watchdog cannot be stopped by any control write. Status bit 0 stays 1 and the counter keeps counting.
- R4: A service is a write of 0xE51A to the key register (0x9C) followed by a write of 0xA35C. If the window is open when the second word is written, the counter reloads to the start value and no fault is raised.
- R5: If a key write breaks the sequence, the machine goes back to waiting for 0xE51A without a reload. This covers any value other than 0xA35C after 0xE51A, a repeated 0xE51A, and a lone 0xA35C.
- R6: A service completed while the window is still closed raises a fault (status bit 1).
- R7: When the counter reaches zero with no service, a fault is raised on the next clock and the counter holds at zero.
- R8: Window register (0xA8) value 0x05 opens the window at all times. Value 0x50 opens it when the counter is at or below half the start value. Any other value behaves like 0x50.
- R9: While a fault is latched, reaction value 0xA (register 0xA4, bits 3:0) asserts irq_o only. Any other reaction value asserts rst_req_o only. Both outputs are low when no fault is latched.
- R10: The status register (0x98) reports running in bit 0 and fault in bit 1. The fault stays latched and key writes are ignored until 1 is written to bit 1. That write clears the fault, reloads the counter and resumes counting.
- R11: Reads return the preload, reaction, window, status and counter at their offsets, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Fault output in interrupt reaction mode |
| rst_req_o | output | 1 | Fault output in reset reaction mode |

## Verification
A wrong state in the machine shows up on the ports within a cycle. Status bits 0 and 1 encode whether the machine is dormant, running or tripped, and the counter readback shows a missed or spurious reload on the very next read. A wrong window decision or a wrong expiry cycle appears as status bit 1 and a fault output changing one clock after the key write or zero count that caused it. The scenarios therefore sample the counter at exact cycle offsets from each bus write.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam logic [7:0] A_CTRL   = 8'h90;
    localparam logic [7:0] A_PRE    = 8'h94;
    localparam logic [7:0] A_STAT   = 8'h98;
    localparam logic [7:0] A_KEY    = 8'h9C;
    localparam logic [7:0] A_CNT    = 8'hA0;
    localparam logic [7:0] A_REACT  = 8'hA4;
    localparam logic [7:0] A_WIN    = 8'hA8;

    localparam logic [31:0] K_ENABLE = 32'hA985_59DA;
    localparam logic [31:0] K_SVC1   = 32'h0000_E51A;
    localparam logic [31:0] K_SVC2   = 32'h0000_A35C;

    localparam logic [3:0] REACT_IRQ = 4'hA;
    localparam logic [3:0] REACT_DEF = 4'h5;
    localparam logic [7:0] WIN_FULL  = 8'h05;
    localparam logic [7:0] WIN_HALF  = 8'h50;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2,
        ST_TRIP  = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int CNT_W  = 25,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              running,
    input  logic              fault,
    input  logic [CNT_W-1:0]  cnt,
    output logic [PRE_W-1:0]  preload,
    output logic              win_full,
    output logic              react_irq,
    output logic [DATA_W-1:0] rdata
);

    logic [3:0] react_q;
    logic [7:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload <= '0;
            react_q <= REACT_DEF;
            win_q   <= WIN_FULL;
        end else if (we) begin
            if (addr == A_PRE)   preload <= wdata[PRE_W-1:0];
            if (addr == A_REACT) react_q <= wdata[3:0];
            if (addr == A_WIN)   win_q   <= wdata[7:0];
        end
    end

    assign win_full  = (win_q == WIN_FULL);
    assign react_irq = (react_q == REACT_IRQ);

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'(running);
            A_PRE:   rdata = DATA_W'(preload);
            A_STAT:  rdata = DATA_W'({fault, running});
            A_CNT:   rdata = DATA_W'(cnt);
            A_REACT: rdata = DATA_W'(react_q);
            A_WIN:   rdata = DATA_W'(win_q);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
    parameter int PRE_W = 12,
    parameter int SHIFT = 13,
    localparam int CNT_W = PRE_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] preload,
    input  logic             win_full,
    input  logic             load,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             win_open
);

    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] half;

    assign start = {preload, {SHIFT{1'b0}}};
    assign half  = start >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign cnt_zero = (cnt == '0);
    assign win_open = win_full || (cnt <= half);

    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(start));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> cnt == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_key,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cnt_zero,
    input  logic              win_open,
    output wd_state_e         state,
    output logic              load,
    output logic              run,
    output logic              running,
    output logic              fault
);

    wd_state_e nxt;
    logic      key1_hit;
    logic      key2_hit;
    logic      en_hit;
    logic      clr_hit;

    assign en_hit   = wr_ctrl && (wdata == K_ENABLE);
    assign key1_hit = wr_key && (wdata == K_SVC1);
    assign key2_hit = wr_key && (wdata == K_SVC2);
    assign clr_hit  = wr_stat && wdata[1];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en_hit) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (cnt_zero)      nxt = ST_TRIP;
                else if (key1_hit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (cnt_zero)      nxt = ST_TRIP;
                else if (key2_hit) nxt = win_open ? ST_RUN : ST_TRIP;
                else if (wr_key)   nxt = ST_RUN;
            end
            ST_TRIP: begin
                if (clr_hit) nxt = ST_RUN;
            end
        endcase
    end

    always_comb begin
        load    = 1'b0;
        run     = 1'b0;
        running = 1'b1;
        fault   = 1'b0;
        unique case (state)
            ST_OFF: begin
                running = 1'b0;
                load    = en_hit;
            end
            ST_RUN: begin
                run = 1'b1;
            end
            ST_ARMED: begin
                run  = 1'b1;
                load = !cnt_zero && key2_hit && win_open;
            end
            ST_TRIP: begin
                fault = 1'b1;
                load  = clr_hit;
            end
        endcase
    end

    assert_stay_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_OFF |=> state != ST_OFF);

    assert_early_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && key2_hit && !win_open) |=> state == ST_TRIP);

    assert_expiry_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN || state == ST_ARMED) && cnt_zero) |=> state == ST_TRIP);

    assert_trip_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && !clr_hit) |=> state == ST_TRIP);

    assert_bad_key_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wr_key) |-> !load);

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdw_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int SHIFT  = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);

    localparam int CNT_W = PRE_W + SHIFT;

    wd_state_e        state;
    logic [PRE_W-1:0] preload;
    logic [CNT_W-1:0] cnt;
    logic             win_full;
    logic             react_irq;
    logic             load;
    logic             run;
    logic             running;
    logic             fault;
    logic             cnt_zero;
    logic             win_open;
    logic             wr_ctrl;
    logic             wr_key;
    logic             wr_stat;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_key  = bus_we && (bus_addr == A_KEY);
    assign wr_stat = bus_we && (bus_addr == A_STAT);

    wdw_regs #(
        .PRE_W (PRE_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .running  (running),
        .fault    (fault),
        .cnt      (cnt),
        .preload  (preload),
        .win_full (win_full),
        .react_irq(react_irq),
        .rdata    (bus_rdata)
    );

    wdw_counter #(
        .PRE_W(PRE_W),
        .SHIFT(SHIFT)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .preload (preload),
        .win_full(win_full),
        .load    (load),
        .run     (run),
        .cnt     (cnt),
        .cnt_zero(cnt_zero),
        .win_open(win_open)
    );

    wdw_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_key  (wr_key),
        .wr_stat (wr_stat),
        .wdata   (bus_wdata),
        .cnt_zero(cnt_zero),
        .win_open(win_open),
        .state   (state),
        .load    (load),
        .run     (run),
        .running (running),
        .fault   (fault)
    );

    always_comb begin
        irq_o     = fault && react_irq;
        rst_req_o = fault && !react_irq;
    end

    assert_one_reaction_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, rst_req_o}));

    assert_fault_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP) |-> (irq_o || rst_req_o));

endmodule

// File: tb/wdog_window_test.sv
module wdog_window_test;

    localparam int SH = 4;
    localparam logic [31:0] PRE = 32'h10;
    localparam logic [31:0] P = PRE << SH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_window #(.SHIFT(SH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start(input logic [31:0] win, input logic [31:0] react);
        do_reset();
        wr(8'h94, PRE);
        wr(8'hA8, win);
        wr(8'hA4, react);
        wr(8'h90, 32'hA985_59DA);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h98, v); chk("R1 status", v, 0);
        rd(8'hA0, v); chk("R1 counter", v, 0);
        rd(8'hA4, v); chk("R1 reaction", v, 32'h5);
        rd(8'hA8, v); chk("R1 window", v, 32'h05);
        chk("R1 outputs", {irq_o, rst_req_o}, 0);
        wr(8'h94, 32'hFFFF_F123);
        rd(8'h94, v); chk("R11 preload readback", v, 32'h123);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        do_reset();
        wr(8'h94, PRE);
        wr(8'h90, 32'h1234_5678);
        rd(8'h98, v); chk("R2 wrong key stays dormant", v, 0);
        rd(8'hA0, v); chk("R2 wrong key no count", v, 0);
        wr(8'h90, 32'hA985_59DA);
        rd(8'hA0, v); chk("R2 load value", v, P);
        repeat (10) @(negedge clk);
        rd(8'hA0, v); chk("R2 decrement", v, P - 10);
        wr(8'h90, 32'h0);
        rd(8'h98, v); chk("R3 still running", v, 1);
        rd(8'hA0, v); chk("R3 still counting", v, P - 11);
    endtask

    task automatic t_service_ok();
        logic [31:0] v;
        start(32'h50, 32'h5);
        repeat (140) @(negedge clk);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'hA0, v); chk("R4 reload in window", v, P);
        rd(8'h98, v); chk("R4 no fault", v, 1);
    endtask

    task automatic t_early();
        logic [31:0] v;
        start(32'h50, 32'h5);
        repeat (20) @(negedge clk);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'h98, v); chk("R6 early service faults", v, 3);
        chk("R9 reset reaction", {irq_o, rst_req_o}, 2'b01);
        wr(8'h98, 32'h2);
        rd(8'h98, v); chk("R10 fault cleared", v, 1);
        rd(8'hA0, v); chk("R10 clear reloads", v, P);
        chk("R10 outputs low", {irq_o, rst_req_o}, 0);
    endtask

    task automatic t_windows();
        logic [31:0] v;
        start(32'h05, 32'h5);
        repeat (5) @(negedge clk);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'hA0, v); chk("R8 full window reload", v, P);
        rd(8'h98, v); chk("R8 full window no fault", v, 1);
        start(32'h33, 32'h5);
        repeat (5) @(negedge clk);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'h98, v); chk("R8 other code acts as half", v, 3);
    endtask

    task automatic t_bad_seq();
        logic [31:0] v;
        start(32'h05, 32'h5);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'h1234);
        wr(8'h9C, 32'hA35C);
        rd(8'hA0, v); chk("R5 broken sequence no reload", v, P - 3);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'hA0, v); chk("R5 repeated first key no reload", v, P - 6);
        rd(8'h98, v); chk("R5 no fault", v, 1);
    endtask

    task automatic t_expiry();
        logic [31:0] v;
        start(32'h50, 32'hA);
        repeat (P) @(negedge clk);
        rd(8'hA0, v); chk("R7 counter at zero", v, 0);
        rd(8'h98, v); chk("R7 not yet faulted", v, 1);
        @(negedge clk);
        rd(8'h98, v); chk("R7 expiry fault", v, 3);
        chk("R9 irq reaction", {irq_o, rst_req_o}, 2'b10);
        repeat (5) @(negedge clk);
        wr(8'h9C, 32'hE51A);
        wr(8'h9C, 32'hA35C);
        rd(8'h98, v); chk("R10 fault latched through keys", v, 3);
        rd(8'hA0, v); chk("R7 counter holds zero", v, 0);
        chk("R9 irq stays", {irq_o, rst_req_o}, 2'b10);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_service_ok();
        t_early();
        t_windows();
        t_bad_seq();
        t_expiry();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule